// File: doc/BRIEF.md
# Cache Reuse-Distance Histogram Unit

This block watches a stream of memory access addresses, either instruction fetches or data references, and keeps a shadow copy of the least-recently-used ordering of every set of a set-associative cache. It holds only tags and valid bits and never stores line data. For each access it finds the tag's depth in its set's recency stack. Depth 0 is the most recently used entry. When the tag is absent, the access counts as a miss. The block adds one to the histogram bin for that depth, then moves the tag to the front of the stack.

Software or a readout engine selects one bin at a time and reads its wide counter. The result is a reuse profile: how many accesses found their line one, two or more positions back in recency order, and how many missed.

The access port is a valid/ready stream. A beat transfers on a clock edge where both `acc_valid` and `acc_ready` are high. `acc_ready` is low only in a cycle where `clear` is asserted, and during that cycle the beat must be held. The source may keep `acc_valid` high for any number of cycles, and the block takes one access per cycle. `enable`, `clear` and the readout pins are plain control pins with no handshake.

Top module: `reuse_hist`

## Requirements
- R1: The set index is taken from address bits [OFF_W+IDX_W-1:OFF_W], with OFF_W = log2(LINE_BYTES) and IDX_W = log2(SETS). The tag is taken from the bits above the set index. Accesses that differ only in the low OFF_W bits refer to the same line.
- R2: When the tag is valid in its set, the reuse distance is the tag's stack position k, counting from 0 at the most recent entry. The access increments bin k.
- R3: When the tag is not valid in its set, the access increments the miss bin, which has index WAYS.
- R4: After an enabled access, the accessed tag is at position 0 of its set. On a hit at position k, the entries at positions 0..k-1 each move one position deeper. On a miss, all entries move one position deeper and the entry at position WAYS-1 is dropped.
- R5: An access accepted at clock edge E shows up in `rd_count` after clock edge E+1. Accesses may arrive on consecutive cycles, and each one sees the stack as updated by the access before it.
- R6: Reset, and any cycle with `clear` high, invalidate every stack entry and set every bin to zero. A bin increment still pending from the previous access is dropped. `acc_ready` is low exactly in the cycles where `clear` is high.
- R7: An access accepted while `enable` is low changes neither the stacks nor the histogram.
- R8: Each set keeps its own stack. The same tag in two different sets is tracked as two different lines.
- R9: `rd_count` shows the bin chosen by `rd_sel` for values 0..WAYS, and shows zero for any larger value of `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Profiling on; when low, accepted accesses are discarded |
| clear | input | 1 | Invalidate all stacks and zero all bins this cycle |
| acc_valid | input | 1 | Access beat valid |
| acc_ready | output | 1 | Access beat can be taken |
| acc_addr | input | ADDR_W | Byte address of the access |
| rd_sel | input | DIST_W | Histogram bin to read (WAYS is the miss bin) |
| rd_count | output | CNT_W | Counter value of the selected bin |

## Verification
The bench goes after streams where one line is hit at each recency depth, including the deepest. A design that shifts the wrong span of the stack would then report later hits at the wrong depth. It sends back-to-back accesses to the same set, which expose a lookup that reads the stack before the previous update has been written. It uses the same tag in two different sets, and it also sends addresses that differ only in the offset bits, which catch errors in the address slicing. It drives `clear` in the cycle that would have applied a pending increment, and it drives accesses while `enable` is low. A design that got either case wrong would leave a stray count or a stale tag that hits when it should miss.

// File: rtl/reuse_pkg.sv
package reuse_pkg;
  localparam int unsigned DEF_WAYS       = 2;
  localparam int unsigned DEF_SETS       = 64;
  localparam int unsigned DEF_LINE_BYTES = 32;
  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_CNT_W      = 40;

  // Width needed to hold values 0..n-1 (at least one bit).
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rh_addr_split.sv
module rh_addr_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 5,
  parameter int unsigned IDX_W  = 6,
  localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  set_o,
  output logic [TAG_W-1:0]  tag_o
);
  // R1: offset bits are dropped; set index sits directly above them.
  assign set_o = addr_i[OFF_W +: IDX_W];
  assign tag_o = addr_i[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/rh_lru_stacks.sv
module rh_lru_stacks #(
  parameter int unsigned WAYS  = 2,
  parameter int unsigned SETS  = 64,
  parameter int unsigned TAG_W = 21,
  localparam int unsigned IDX_W  = reuse_pkg::idx_width(SETS),
  localparam int unsigned POS_W  = reuse_pkg::idx_width(WAYS),
  localparam int unsigned DIST_W = $clog2(WAYS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              upd_i,     // accepted and enabled access
  input  logic              fire_i,    // accepted access regardless of enable
  input  logic              en_i,
  input  logic [IDX_W-1:0]  set_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              inc_v_o,
  output logic [DIST_W-1:0] inc_bin_o
);
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic             vld_q [SETS][WAYS];

  logic [TAG_W-1:0] row_t [WAYS];
  logic             row_v [WAYS];
  logic [WAYS-1:0]  match;
  logic             hit;
  logic [POS_W-1:0] hpos;
  logic [POS_W-1:0] lim;
  logic [TAG_W-1:0] nt [WAYS];
  logic             nv [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_row
    assign row_t[w] = tag_q[set_i][w];
    assign row_v[w] = vld_q[set_i][w];
    assign match[w] = row_v[w] && (row_t[w] == tag_i);
  end

  always_comb begin
    hit  = 1'b0;
    hpos = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) begin
        hit  = 1'b1;
        hpos = POS_W'(w);
      end
    end
  end

  // Deepest position that moves: the hit slot, or the bottom on a miss.
  assign lim = hit ? hpos : POS_W'(WAYS - 1);

  assign nt[0] = tag_i;
  assign nv[0] = 1'b1;
  for (genvar j = 1; j < WAYS; j++) begin : g_shift
    always_comb begin
      if (POS_W'(j) <= lim) begin
        nt[j] = row_t[j-1];
        nv[j] = row_v[j-1];
      end else begin
        nt[j] = row_t[j];
        nv[j] = row_v[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          vld_q[s][w] <= 1'b0;
    end else if (upd_i) begin
      for (int w = 0; w < WAYS; w++) vld_q[set_i][w] <= nv[w];
    end
  end

  always_ff @(posedge clk) begin
    if (upd_i && !clear_i) begin
      for (int w = 0; w < WAYS; w++) tag_q[set_i][w] <= nt[w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      inc_v_o   <= 1'b0;
      inc_bin_o <= '0;
    end else begin
      inc_v_o   <= upd_i;
      inc_bin_o <= hit ? DIST_W'(hpos) : DIST_W'(WAYS);
    end
  end

  // R2: a tag lives at most once in its stack.
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(match) <= 1);

  // R4: the accessed tag becomes the most recent valid entry.
  a_r4_mru_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !clear_i) |=> (vld_q[$past(set_i)][0] && tag_q[$past(set_i)][0] == $past(tag_i)));

  // R7: a disabled access schedules no increment.
  a_r7_no_count_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !en_i) |=> !inc_v_o);
endmodule

// File: rtl/rh_histogram.sv
module rh_histogram #(
  parameter int unsigned BINS  = 3,
  parameter int unsigned CNT_W = 40,
  localparam int unsigned SEL_W = $clog2(BINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             inc_v_i,
  input  logic [SEL_W-1:0] inc_bin_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [CNT_W-1:0] rd_count_o
);
  logic [CNT_W-1:0] bins_q [BINS];

  for (genvar b = 0; b < BINS; b++) begin : g_bin
    always_ff @(posedge clk) begin
      if (!rst_n || clear_i)                          bins_q[b] <= '0;
      else if (inc_v_i && inc_bin_i == SEL_W'(b))     bins_q[b] <= bins_q[b] + 1'b1;
    end

    // R5: a pending increment lands in its bin on the next edge.
    a_r5_bin_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_v_i && !clear_i && inc_bin_i == SEL_W'(b)) |=> (bins_q[b] == $past(bins_q[b]) + 1'b1));

    // R6: clear empties every bin.
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (bins_q[b] == '0));
  end

  // R9: selections past the miss bin read as zero.
  always_comb begin
    rd_count_o = '0;
    for (int b = 0; b < BINS; b++)
      if (rd_sel_i == SEL_W'(b)) rd_count_o = bins_q[b];
  end
endmodule

// File: rtl/reuse_hist.sv
module reuse_hist #(
  parameter int unsigned WAYS       = reuse_pkg::DEF_WAYS,
  parameter int unsigned SETS       = reuse_pkg::DEF_SETS,
  parameter int unsigned LINE_BYTES = reuse_pkg::DEF_LINE_BYTES,
  parameter int unsigned ADDR_W     = reuse_pkg::DEF_ADDR_W,
  parameter int unsigned CNT_W      = reuse_pkg::DEF_CNT_W,
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned IDX_W  = reuse_pkg::idx_width(SETS),
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned BINS   = WAYS + 1,
  localparam int unsigned DIST_W = $clog2(BINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              clear,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DIST_W-1:0] rd_sel,
  output logic [CNT_W-1:0]  rd_count
);
  logic             fire;
  logic             upd;
  logic [IDX_W-1:0] set_idx;
  logic [TAG_W-1:0] tag;
  logic             inc_v;
  logic [DIST_W-1:0] inc_bin;

  assign acc_ready = !clear;
  assign fire      = acc_valid && acc_ready;
  assign upd       = fire && enable;

  rh_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
    .addr_i(acc_addr), .set_o(set_idx), .tag_o(tag)
  );

  rh_lru_stacks #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_stacks (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .upd_i(upd), .fire_i(fire),
    .en_i(enable), .set_i(set_idx), .tag_i(tag),
    .inc_v_o(inc_v), .inc_bin_o(inc_bin)
  );

  rh_histogram #(.BINS(BINS), .CNT_W(CNT_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .inc_v_i(inc_v),
    .inc_bin_i(inc_bin), .rd_sel_i(rd_sel), .rd_count_o(rd_count)
  );

  // R6: nothing is counted in the cycle after a clear.
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !inc_v);
endmodule

// File: tb/sim_reuse_hist.sv
`timescale 1ns/1ps
module sim_reuse_hist;
  localparam int WAYS = 2, SETS = 64, OFF = 5, IDX = 6, ADDR_W = 32, CNT_W = 40;
  localparam int DIST_W = $clog2(WAYS + 1);

  logic clk = 0, rst_n = 0, enable = 0, clear = 0, acc_valid = 0, acc_ready;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [DIST_W-1:0] rd_sel = '0;
  logic [CNT_W-1:0]  rd_count;

  int vecs = 0, errs = 0;
  bit done = 0;
  int rot = 0;

  always #2 clk = ~clk;

  reuse_hist u0 (.clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
    .rd_sel(rd_sel), .rd_count(rd_count));

  // Behavioural reference: recency lists per set, counts, one pending bump.
  int unsigned q[SETS][$];
  longint m_bins[WAYS+1];
  bit m_pend;
  int m_pbin;

  always @(posedge clk) begin
    if (!rst_n || clear) begin
      for (int s = 0; s < SETS; s++) q[s].delete();
      for (int b = 0; b <= WAYS; b++) m_bins[b] = 0;
      m_pend = 0;
    end else begin
      if (m_pend) m_bins[m_pbin]++;
      m_pend = 0;
      if (acc_valid && enable) begin
        int s, d;
        int unsigned t;
        s = int'((acc_addr >> OFF) & (SETS - 1));
        t = acc_addr >> (OFF + IDX);
        d = WAYS;
        for (int k = 0; k < q[s].size(); k++) if (q[s][k] == t) d = k;
        if (d < WAYS) q[s].delete(d);
        q[s].push_front(t);
        if (q[s].size() > WAYS) void'(q[s].pop_back());
        m_pend = 1;
        m_pbin = d;
      end
    end
  end

  task automatic check(string req, longint act, longint exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Compare every clock, between edges.
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      longint e;
      e = (int'(rd_sel) <= WAYS) ? m_bins[rd_sel] : 0;
      check(int'(rd_sel) < WAYS ? "R2 hit bin" : (int'(rd_sel) == WAYS ? "R3 miss bin" : "R9 out-of-range bin"),
            longint'(rd_count), e);
      check("R6 ready", longint'(acc_ready), longint'(!clear));
    end
  end

  function automatic logic [ADDR_W-1:0] mk(int tag, int set, int off);
    return ADDR_W'((tag << (OFF + IDX)) | (set << OFF) | off);
  endfunction

  task automatic step(bit v, logic [ADDR_W-1:0] a);
    acc_valid = v;
    acc_addr  = a;
    rd_sel    = DIST_W'(rot % (1 << DIST_W));
    rot++;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0);
  endtask

  task automatic peek(int bin, string req, longint exp);
    rd_sel = DIST_W'(bin);
    #0.5;
    check(req, longint'(rd_count), exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errs++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst_n = 1;
    for (int b = 0; b <= WAYS; b++) peek(b, "R6 reset zero", 0);
    enable = 1;
    // Set 0: A miss, A d0, B miss, A d1, A d0, C miss (evicts B), B miss
    step(1, mk(1, 0, 0)); step(1, mk(1, 0, 4)); step(1, mk(2, 0, 0));
    step(1, mk(1, 0, 8)); step(1, mk(1, 0, 0)); step(1, mk(3, 0, 0));
    step(1, mk(2, 0, 0));
    idle(2);
    peek(0, "R2 depth0 count", 2); peek(1, "R2 depth1 count", 1);
    peek(WAYS, "R3 miss count", 4);
    // Stack now [B,C]: C at depth 1 (R4 shifting and eviction)
    step(1, mk(3, 0, 0)); idle(2);
    peek(1, "R4 shifted depth", 2);
    // Same tag, other set: separate line
    step(1, mk(1, 1, 0)); idle(2);
    peek(WAYS, "R8 per-set miss", 5);
    // Offset-only difference: same line, back-to-back
    step(1, mk(1, 1, 31)); idle(2);
    peek(0, "R1 offset ignored", 3);
    peek(0, "R5 back-to-back", 3);
    // Disabled accesses: C is at depth 0 of set 0 before and after
    enable = 0;
    step(1, mk(7, 0, 0)); step(1, mk(8, 0, 0)); idle(2);
    enable = 1;
    peek(WAYS, "R7 disabled no miss", 5);
    step(1, mk(3, 0, 0)); idle(2);
    peek(0, "R7 stack untouched", 4);
    // R5 timing: count not yet visible one negedge after acceptance
    step(1, mk(3, 0, 0));
    peek(0, "R5 latency before", 4);
    clear = 1; step(0, '0); clear = 0;
    idle(1);
    peek(0, "R6 pending dropped", 0);
    step(1, mk(3, 0, 0)); idle(2);
    peek(WAYS, "R6 stacks invalidated", 1);
    peek(3, "R9 out-of-range zero", 0);
    // Random traffic on a small tag/set pool
    for (int i = 0; i < 4000; i++) begin
      enable = ($urandom % 16) != 0;
      clear  = ($urandom % 200) == 0;
      step(($urandom % 4) != 0, mk($urandom % 5, $urandom % 3, $urandom % 32));
    end
    clear = 0;
    idle(4);
    finish_run();
  end
endmodule